// File: doc/BRIEF.md
# Randomized Stationary Power-Command Selector

This block is the decision stage of a discrete-time power manager. At each periodic decision point, marked by a one-cycle `tick` pulse, it forms a system-state index from three observed quantities: the workload (requester) state, the managed component (provider) state and the occupancy of the queue between them. It then issues one command from a small fixed set to the managed component. The choice depends only on the state seen at that tick. It does not depend on any earlier decision.

The policy is held in a writable table. Each state row stores one 8-bit cumulative threshold per command. A 16-bit linear-feedback shift register supplies an 8-bit random sample at every tick, and the sample is compared against the row to pick the command. Software computes the policy offline and loads it through the write port. Once loaded, the policy is stationary: the table only changes when it is written again. The random source can be seeded, so the same seed and the same state sequence give the same command sequence.

Top module: `rand_policy_pm`

## Requirements
- R1: After reset, `cmd_valid` is 0, `cmd_out` is 0, every threshold in the table is 255 (so every state issues command 0), and the random register holds 16'hACE1.
- R2: `cmd_valid` is 1 in exactly the cycle after a cycle with `tick` high and 0 otherwise. `cmd_out` changes only on those updates and holds its value between ticks.
- R3: The state index is the concatenation {`req_state`, `prov_state`, `queue_lvl`}, with `req_state` in the most significant bits. `wr_state` addresses table rows with the same layout, and each row is selected independently.
- R4: At a tick, the issued command is the lowest command number c whose threshold in the current row is either greater than the sample or equal to 255. If no command qualifies, the highest command number is issued.
- R5: The sample is bits [7:0] of the random register as it stands at the tick. Each tick then advances the register once: the new bit 0 is the XOR of bits 15, 13, 12 and 10, and the other bits shift up by one place. The register never holds zero and does not change in cycles without a tick or a seed write.
- R6: `seed_we` loads `seed_val` into the random register, or 16'h0001 when `seed_val` is zero. The loaded value is visible from the next cycle.
- R7: A table write made in the same cycle as a tick does not affect that tick's command. It takes effect from the following tick.
- R8: A row gives a deterministic command k when thresholds 0..k-1 are 0 and threshold k is 255. A row with every threshold 0 always gives the highest command.
- R9: Reloading the same seed and repeating the same sequence of states at the ticks reproduces the same sequence of commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Decision-point pulse |
| req_state | input | 2 | Service requester state |
| prov_state | input | 2 | Service provider state |
| queue_lvl | input | 2 | Queue occupancy |
| wr_en | input | 1 | Table write strobe |
| wr_state | input | 6 | Row (state index) to write |
| wr_cmd | input | 2 | Command column to write |
| wr_thresh | input | 8 | Cumulative threshold value |
| seed_we | input | 1 | Random register seed load |
| seed_val | input | 16 | Seed value |
| cmd_out | output | 2 | Issued command |
| cmd_valid | output | 1 | One-cycle pulse marking a new command |

## Verification
The hardest case to reach from the ports is a table write that lands in the same cycle as a tick on the very row being decided. The bench drives `wr_en` and `tick` together on one row and changes that row so the old and new contents must give different commands, then checks the command at that tick and at the next one. Checking the random selection exactly also requires knowing the random register's value, so every random scenario starts with a seed load. From that point the bench steps its own model of the register alongside the design, and compares every command over long runs of ticks against thresholds that split the sample range.

// File: rtl/rpp_pkg.sv
// Package: shared widths and types for the randomized policy selector.
// Assumes an 8-bit probability resolution and a 16-bit random register.
package rpp_pkg;
    localparam int PROB_W = 8;
    localparam int RND_W  = 16;
    localparam logic [RND_W-1:0] RND_TAPS  = 16'hB400; // bits 15,13,12,10
    localparam logic [RND_W-1:0] RND_RESET = 16'hACE1;
    localparam logic [PROB_W-1:0] PROB_FULL = {PROB_W{1'b1}};

    typedef logic [PROB_W-1:0] prob_t;
    typedef logic [RND_W-1:0]  rnd_t;
endpackage

// File: rtl/rpp_table.sv
// Module: policy storage. One row per system state, one cumulative
// threshold per command. Reads are combinational, so a write at an edge
// is seen by decisions only from the following edge.
// Assumes wr_state < NSTATE (always true when NSTATE = 2**IDX_W).
module rpp_table
    import rpp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int NCMD  = 4,
    localparam int NSTATE = 1 << IDX_W,
    localparam int CMD_W  = (NCMD > 1) ? $clog2(NCMD) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_state,
    input  logic [CMD_W-1:0]       wr_cmd,
    input  prob_t                  wr_thresh,
    input  logic [IDX_W-1:0]       rd_state,
    output logic [NCMD*PROB_W-1:0] rd_row
);
    logic [NCMD*PROB_W-1:0] row_q [NSTATE];

    for (genvar s = 0; s < NSTATE; s++) begin : g_row
        for (genvar c = 0; c < NCMD; c++) begin : g_col
            // Hold one threshold; reset to full range, write when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    row_q[s][c*PROB_W +: PROB_W] <= PROB_FULL;
                else if (wr_en && (wr_state == IDX_W'(s)) && (wr_cmd == CMD_W'(c)))
                    row_q[s][c*PROB_W +: PROB_W] <= wr_thresh;
            end
        end
    end

    // Present the row of the state being decided.
    always_comb rd_row = row_q[rd_state];
endmodule

// File: rtl/rpp_lfsr.sv
// Module: seedable Fibonacci shift register that supplies random samples.
// Advances once per 'adv'; a seed load takes precedence. A zero seed is
// replaced by 1 so the register never locks up.
module rpp_lfsr
    import rpp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic seed_we,
    input  rnd_t seed_val,
    output rnd_t state
);
    rnd_t state_q;
    logic fb;

    // Feedback bit from the tap mask.
    always_comb fb = ^(state_q & RND_TAPS);

    // Register update: reset, seed load, or one shift step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RND_RESET;
        else if (seed_we)
            state_q <= (seed_val == '0) ? rnd_t'(1) : seed_val;
        else if (adv)
            state_q <= {state_q[RND_W-2:0], fb};
    end

    assign state = state_q;
endmodule

// File: rtl/rpp_select.sv
// Module: combinational command picker. Issues the lowest command whose
// threshold is above the sample or saturated at full scale; otherwise the
// highest command. Assumes thresholds are laid out command 0 in the low bits.
module rpp_select
    import rpp_pkg::*;
#(
    parameter int NCMD = 4,
    localparam int CMD_W = (NCMD > 1) ? $clog2(NCMD) : 1
) (
    input  logic [NCMD*PROB_W-1:0] row,
    input  prob_t                  sample,
    output logic [CMD_W-1:0]       cmd
);
    logic [NCMD-1:0] hit;

    for (genvar c = 0; c < NCMD; c++) begin : g_hit
        // One comparator per command column.
        always_comb hit[c] = (row[c*PROB_W +: PROB_W] > sample) ||
                             (row[c*PROB_W +: PROB_W] == PROB_FULL);
    end

    // Priority pick: scan downward so the lowest hit wins.
    always_comb begin
        cmd = CMD_W'(NCMD - 1);
        for (int c = NCMD - 1; c >= 0; c--) begin
            if (hit[c]) cmd = CMD_W'(c);
        end
    end
endmodule

// File: rtl/rand_policy_pm.sv
// Module: top of the randomized stationary power-command selector.
// At each tick the current state row and random sample choose a command,
// which is registered with a one-cycle valid pulse. Assumes tick is a
// single-cycle pulse generated at the decision period.
module rand_policy_pm
    import rpp_pkg::*;
#(
    parameter int SR_W = 2,
    parameter int SP_W = 2,
    parameter int Q_W  = 2,
    parameter int NCMD = 4,
    localparam int IDX_W = SR_W + SP_W + Q_W,
    localparam int CMD_W = (NCMD > 1) ? $clog2(NCMD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SR_W-1:0]  req_state,
    input  logic [SP_W-1:0]  prov_state,
    input  logic [Q_W-1:0]   queue_lvl,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_state,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic [PROB_W-1:0] wr_thresh,
    input  logic             seed_we,
    input  logic [RND_W-1:0] seed_val,
    output logic [CMD_W-1:0] cmd_out,
    output logic             cmd_valid
);
    logic [IDX_W-1:0]       cur_idx;
    logic [NCMD*PROB_W-1:0] cur_row;
    rnd_t                   rnd_state;
    logic [CMD_W-1:0]       pick;
    logic [CMD_W-1:0]       cmd_q;
    logic                   valid_q;

    // Form the system-state index, requester state most significant.
    always_comb cur_idx = {req_state, prov_state, queue_lvl};

    rpp_table #(.IDX_W(IDX_W), .NCMD(NCMD)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_state (wr_state),
        .wr_cmd   (wr_cmd),
        .wr_thresh(wr_thresh),
        .rd_state (cur_idx),
        .rd_row   (cur_row)
    );

    rpp_lfsr lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (tick),
        .seed_we (seed_we),
        .seed_val(seed_val),
        .state   (rnd_state)
    );

    rpp_select #(.NCMD(NCMD)) select_i (
        .row   (cur_row),
        .sample(rnd_state[PROB_W-1:0]),
        .cmd   (pick)
    );

    // Register the command at a tick and mark it valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick;
            if (tick) cmd_q <= pick;
        end
    end

    assign cmd_out   = cmd_q;
    assign cmd_valid = valid_q;
endmodule

// File: rtl/rand_policy_pm_chk.sv
// Module: assertion checker for rand_policy_pm, attached by bind.
module rand_policy_pm_chk
    import rpp_pkg::*;
#(
    parameter int CMD_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             seed_we,
    input logic [RND_W-1:0] seed_val,
    input logic [CMD_W-1:0] cmd_out,
    input logic             cmd_valid,
    input logic [RND_W-1:0] rnd_state
);
    p_valid_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cmd_valid);
    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !cmd_valid);
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cmd_out));
    p_rnd_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_state != '0);
    p_rnd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !seed_we) |=> $stable(rnd_state));
    p_rnd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !seed_we) |=> (rnd_state != $past(rnd_state)));
    p_seed_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_we |=> (rnd_state == (($past(seed_val) == '0) ? RND_W'(1) : $past(seed_val))));
endmodule

bind rand_policy_pm rand_policy_pm_chk #(.CMD_W(CMD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .seed_we  (seed_we),
    .seed_val (seed_val),
    .cmd_out  (cmd_out),
    .cmd_valid(cmd_valid),
    .rnd_state(rnd_state)
);

// File: tb/rand_policy_pm_tb_top.sv
// Bench: directed scenarios with an independent model of the table and
// the random register built from the requirements.
module rand_policy_pm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  req_state = '0, prov_state = '0, queue_lvl = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_state = '0;
    logic [1:0]  wr_cmd = '0;
    logic [7:0]  wr_thresh = '0;
    logic        seed_we = 1'b0;
    logic [15:0] seed_val = '0;
    logic [1:0]  cmd_out;
    logic        cmd_valid;

    int errors = 0;
    int checks = 0;
    logic [7:0]  m_thr [64][4];
    logic [15:0] m_rnd;
    logic [1:0]  rec [10];
    bit          done = 0;

    always #2 clk = ~clk; // 250 MHz

    rand_policy_pm dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_state(req_state), .prov_state(prov_state), .queue_lvl(queue_lvl),
        .wr_en(wr_en), .wr_state(wr_state), .wr_cmd(wr_cmd), .wr_thresh(wr_thresh),
        .seed_we(seed_we), .seed_val(seed_val),
        .cmd_out(cmd_out), .cmd_valid(cmd_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] m_pick(input logic [5:0] idx, input logic [7:0] s);
        for (int c = 0; c < 4; c++)
            if (m_thr[idx][c] > s || m_thr[idx][c] == 8'hFF) return 2'(c);
        return 2'd3;
    endfunction

    function automatic logic [15:0] m_step(input logic [15:0] r);
        return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    endfunction

    // One tick in state (r,p,q); returns the issued command after checking it.
    task automatic do_tick(input logic [1:0] r, input logic [1:0] p, input logic [1:0] q,
                           input string req, output logic [1:0] got);
        logic [1:0] exp;
        req_state = r; prov_state = p; queue_lvl = q;
        tick = 1'b1;
        exp = m_pick({r, p, q}, m_rnd[7:0]);
        @(negedge clk);
        tick = 1'b0;
        m_rnd = m_step(m_rnd);
        got = cmd_out;
        check(cmd_valid == 1'b1, req, int'(cmd_valid), 1);
        check(cmd_out == exp, req, int'(cmd_out), int'(exp));
    endtask

    task automatic wr(input logic [5:0] s, input logic [1:0] c, input logic [7:0] t);
        wr_en = 1'b1; wr_state = s; wr_cmd = c; wr_thresh = t;
        @(negedge clk);
        wr_en = 1'b0;
        m_thr[s][c] = t;
    endtask

    task automatic wr_row(input logic [5:0] s, input logic [7:0] t0, input logic [7:0] t1,
                          input logic [7:0] t2, input logic [7:0] t3);
        wr(s, 2'd0, t0); wr(s, 2'd1, t1); wr(s, 2'd2, t2); wr(s, 2'd3, t3);
    endtask

    task automatic seed(input logic [15:0] v);
        seed_we = 1'b1; seed_val = v;
        @(negedge clk);
        seed_we = 1'b0;
        m_rnd = (v == 0) ? 16'h0001 : v;
    endtask

    task automatic t_reset();
        logic [1:0] g;
        check(cmd_valid == 1'b0, "R1 valid", int'(cmd_valid), 0);
        check(cmd_out == 2'd0, "R1 cmd", int'(cmd_out), 0);
        do_tick(2'd3, 2'd1, 2'd2, "R1 default row", g);
        do_tick(2'd0, 2'd0, 2'd0, "R1 default row", g);
    endtask

    task automatic t_idle();
        logic [1:0] g;
        logic [1:0] held;
        do_tick(2'd0, 2'd0, 2'd0, "R2 tick", g);
        held = cmd_out;
        for (int i = 0; i < 5; i++) begin
            req_state = 2'(i); queue_lvl = 2'(i + 1);
            @(negedge clk);
            check(cmd_valid == 1'b0, "R2 idle valid", int'(cmd_valid), 0);
            check(cmd_out == held, "R2 idle hold", int'(cmd_out), int'(held));
        end
    endtask

    task automatic t_rows();
        logic [1:0] g;
        wr_row(6'b01_00_00, 8'd0, 8'd0, 8'hFF, 8'd0);   // req=1 row -> cmd 2
        wr_row(6'b00_00_01, 8'd0, 8'hFF, 8'd0, 8'd0);   // queue=1 row -> cmd 1
        do_tick(2'd1, 2'd0, 2'd0, "R3 req row", g);
        check(g == 2'd2, "R3 req row", int'(g), 2);
        do_tick(2'd0, 2'd0, 2'd1, "R3 queue row", g);
        check(g == 2'd1, "R3 queue row", int'(g), 1);
        do_tick(2'd0, 2'd1, 2'd0, "R3 untouched row", g);
        check(g == 2'd0, "R3 untouched row", int'(g), 0);
    endtask

    task automatic t_determ();
        logic [1:0] g;
        wr_row(6'd40, 8'd0, 8'd0, 8'd0, 8'd0);
        seed(16'h1234);
        for (int i = 0; i < 6; i++) begin
            do_tick(2'd2, 2'd2, 2'd0, "R8 all zero", g);
            check(g == 2'd3, "R8 all zero", int'(g), 3);
        end
    endtask

    task automatic t_random();
        logic [1:0] g;
        int seen [4];
        for (int c = 0; c < 4; c++) seen[c] = 0;
        wr_row(6'd21, 8'd64, 8'd128, 8'd192, 8'd200);
        seed(16'hBEEF);
        for (int i = 0; i < 60; i++) begin
            do_tick(2'd1, 2'd1, 2'd1, "R4 R5 random pick", g);
            seen[g]++;
        end
        for (int c = 0; c < 4; c++)
            check(seen[c] > 0, "R4 every command drawn", seen[c], 1);
    endtask

    task automatic t_seed();
        logic [1:0] g;
        seed(16'h5A5A);
        for (int i = 0; i < 10; i++) do_tick(2'd1, 2'd1, 2'd1, "R9 first run", rec[i]);
        seed(16'h5A5A);
        for (int i = 0; i < 10; i++) begin
            do_tick(2'd1, 2'd1, 2'd1, "R9 replay", g);
            check(g == rec[i], "R9 replay", int'(g), int'(rec[i]));
        end
        seed(16'h0000);
        for (int i = 0; i < 8; i++) do_tick(2'd1, 2'd1, 2'd1, "R6 zero seed", g);
    endtask

    task automatic t_write_tick();
        logic [1:0] g;
        wr_row(6'd50, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        wr(6'd50, 2'd1, 8'hFF);
        // Same cycle: tick on row 50 and overwrite its command-0 threshold.
        req_state = 2'd3; prov_state = 2'd0; queue_lvl = 2'd2;
        tick = 1'b1; wr_en = 1'b1; wr_state = 6'd50; wr_cmd = 2'd0; wr_thresh = 8'd0;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        m_rnd = m_step(m_rnd);
        check(cmd_valid == 1'b1, "R7 write tick valid", int'(cmd_valid), 1);
        check(cmd_out == 2'd0, "R7 old row used", int'(cmd_out), 0);
        m_thr[50][0] = 8'd0;
        do_tick(2'd3, 2'd0, 2'd2, "R7 new row next tick", g);
        check(g == 2'd1, "R7 new row next tick", int'(g), 1);
    endtask

    initial begin
        for (int s = 0; s < 64; s++)
            for (int c = 0; c < 4; c++) m_thr[s][c] = 8'hFF;
        m_rnd = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_rows();
        t_determ();
        t_random();
        t_seed();
        t_write_tick();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule